// File: doc/BRIEF.md
# Bidirectional Row/Column Address Sequencer for a Serial Memory

This block produces the row and column addresses for a memory array that is read and written one word at a time, in sequence. The array is organised as rows of words: 256 rows of 1024 words at the default widths. A transfer-start pulse loads the row counter from an external row address. The same pulse presets the column counter to the bottom or the top of the row, chosen by the direction input. After that, every read/write step pulse moves the column one word up or down. When the column runs off the end of a row, the row counter moves one row in the same direction.

A fast-access mode lets a host stream words without the row being updated. While it is active, the direction is frozen, and a column wrap only raises a pending flag. The next normal step then performs the deferred row move. A chip enable gates every input and the data-enable output, so several sequencers can share one set of data lines. The block has one clock and a synchronous reset. Strobes are one-cycle pulses, and all outputs are registered, so each one reflects an input one clock later.

Top module: `serial_addr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are: row 0, column 0, `dir_now` = 1 (up), `fast_on` = 0, `row_pending` = 0 and `data_oe` = 0.
- R2: With `chip_en` = 1, a `xfer_start` pulse with `dir_up` = 1 loads `row_addr` from `ext_row` and clears `col_addr` to 0. Each later normal step with `dir_up` = 1 adds one to the column.
- R3: With `chip_en` = 1, a `xfer_start` pulse with `dir_up` = 0 loads `row_addr` from `ext_row` and sets `col_addr` to all ones (1023 at the default width). Each later normal step with `dir_up` = 0 subtracts one from the column.
- R4: A normal step that wraps the column moves the row by one in the same direction. Up steps wrap from all ones to 0 and add one to the row. Down steps wrap from 0 to all ones and subtract one from the row. The row counter wraps modulo 2^ROW_W.
- R5: Outside fast-access mode, `dir_up` is taken at each step, so a change of direction takes effect on the very step where it appears. `dir_now` shows the direction of the last step or load.
- R6: `fast_n` (active low) is taken only on enabled cycles without a `rw_step` pulse. `fast_on` shows the result one clock later, and a `fast_n` change during a step pulse has no effect.
- R7: In fast-access mode, `dir_up` is ignored and steps use `dir_now`. A column wrap leaves the row unchanged and sets `row_pending` instead.
- R8: The first normal step taken while `row_pending` = 1 moves the row by one in that step's direction, steps the column and clears `row_pending`.
- R9: While `chip_en` = 0, the strobes, `dir_up` and `fast_n` have no effect on any counter or flag, and `data_oe` is 0 from the next clock.
- R10: `data_oe` becomes 1 one clock after the first enabled `xfer_start`, and stays 1 while `chip_en` remains 1.
- R11: When `xfer_start` and `rw_step` arrive in the same cycle, the load wins and the step is dropped. A load also clears `row_pending`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| chip_en | input | 1 | Device enable; gates all other inputs and `data_oe` |
| xfer_start | input | 1 | One-cycle transfer-start pulse |
| rw_step | input | 1 | One-cycle read/write step pulse |
| dir_up | input | 1 | Direction select, 1 = up, 0 = down |
| fast_n | input | 1 | Fast-access select, active low |
| ext_row | input | ROW_W | External row address loaded on start |
| row_addr | output | ROW_W | Current row address |
| col_addr | output | COL_W | Current column address |
| dir_now | output | 1 | Direction in force (1 = up) |
| fast_on | output | 1 | Fast-access mode active |
| row_pending | output | 1 | A row step is owed from a fast-mode wrap |
| data_oe | output | 1 | Data-enable for a shared data bus |

## Verification
The bench builds the block with ROW_W = 3 and COL_W = 4, so a row holds only 16 words and there are only 8 rows. With those widths, column wraps in both directions, the row wrap from 0 down to 7, and a fast-mode wrap followed by its deferred row step each take a few dozen cycles to reach. A reference model in the bench, written from the requirements, predicts every output after every cycle.

// File: rtl/serial_addr_seq_pkg.sv
package serial_addr_seq_pkg;
   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } step_dir_e;
endpackage

// File: rtl/serial_addr_seq_col.sv
module serial_addr_seq_col
   import serial_addr_seq_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic             step_i,
   input  step_dir_e        dir_i,
   output logic [COL_W-1:0] col_o,
   output logic             edge_o
);
   localparam logic [COL_W-1:0] COL_TOP = {COL_W{1'b1}};
   localparam logic [COL_W-1:0] COL_BOT = '0;
   localparam logic [COL_W-1:0] COL_ONE = COL_W'(1);

   logic [COL_W-1:0] col_q;

   // terminal position in the direction being travelled
   assign edge_o = (dir_i == DIR_UP) ? (col_q == COL_TOP) : (col_q == COL_BOT);
   assign col_o  = col_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         col_q <= COL_BOT;
      end else if (load_i) begin
         col_q <= (dir_i == DIR_UP) ? COL_BOT : COL_TOP;
      end else if (step_i) begin
         col_q <= (dir_i == DIR_UP) ? col_q + COL_ONE : col_q - COL_ONE;
      end
   end
endmodule

// File: rtl/serial_addr_seq_row.sv
module serial_addr_seq_row
   import serial_addr_seq_pkg::*;
#(
   parameter int ROW_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic [ROW_W-1:0] ext_i,
   input  logic             adv_i,
   input  step_dir_e        dir_i,
   output logic [ROW_W-1:0] row_o
);
   logic [ROW_W-1:0] row_q;
   logic [ROW_W-1:0] row_next;

   generate
      if (ROW_W == 1) begin : g_toggle
         // one-bit row: up and down both flip the bit
         assign row_next = ~row_q;
      end else begin : g_addsub
         localparam logic [ROW_W-1:0] ROW_ONE = ROW_W'(1);
         assign row_next = (dir_i == DIR_UP) ? row_q + ROW_ONE : row_q - ROW_ONE;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         row_q <= '0;
      end else if (load_i) begin
         row_q <= ext_i;
      end else if (adv_i) begin
         row_q <= row_next;
      end
   end

   assign row_o = row_q;
endmodule

// File: rtl/serial_addr_seq_mode.sv
module serial_addr_seq_mode
   import serial_addr_seq_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      chip_i,
   input  logic      load_i,
   input  logic      step_i,
   input  logic      rw_raw_i,
   input  logic      dir_in_i,
   input  logic      fast_n_i,
   input  logic      col_edge_i,
   output step_dir_e eff_dir_o,
   output logic      dir_o,
   output logic      fast_o,
   output logic      pend_o,
   output logic      row_adv_o,
   output logic      oe_o
);
   step_dir_e dir_q;
   logic      fast_q;
   logic      pend_q;
   logic      active_q;
   logic      oe_q;

   assign eff_dir_o = fast_q ? dir_q : step_dir_e'(dir_in_i);
   assign row_adv_o = step_i && !fast_q && (col_edge_i || pend_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         dir_q    <= DIR_UP;
         fast_q   <= 1'b0;
         pend_q   <= 1'b0;
         active_q <= 1'b0;
         oe_q     <= 1'b0;
      end else begin
         if (load_i) begin
            dir_q    <= step_dir_e'(dir_in_i);
            pend_q   <= 1'b0;
            active_q <= 1'b1;
         end else if (step_i) begin
            dir_q <= eff_dir_o;
            if (fast_q) begin
               if (col_edge_i) pend_q <= 1'b1;
            end else begin
               pend_q <= 1'b0;
            end
         end
         // mode select only while the read/write strobe is low
         if (chip_i && !rw_raw_i) begin
            fast_q <= !fast_n_i;
         end
         oe_q <= chip_i && (active_q || load_i);
      end
   end

   assign dir_o  = (dir_q == DIR_UP);
   assign fast_o = fast_q;
   assign pend_o = pend_q;
   assign oe_o   = oe_q;
endmodule

// File: rtl/serial_addr_seq.sv
module serial_addr_seq
   import serial_addr_seq_pkg::*;
#(
   parameter int ROW_W = 8,
   parameter int COL_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             chip_en,
   input  logic             xfer_start,
   input  logic             rw_step,
   input  logic             dir_up,
   input  logic             fast_n,
   input  logic [ROW_W-1:0] ext_row,
   output logic [ROW_W-1:0] row_addr,
   output logic [COL_W-1:0] col_addr,
   output logic             dir_now,
   output logic             fast_on,
   output logic             row_pending,
   output logic             data_oe
);
   generate
      if (ROW_W < 1 || ROW_W > 24) begin : g_bad_row
         $error("serial_addr_seq: ROW_W must lie in 1..24");
      end
      if (COL_W < 2 || COL_W > 24) begin : g_bad_col
         $error("serial_addr_seq: COL_W must lie in 2..24");
      end
   endgenerate

   logic      load_g;
   logic      step_g;
   logic      col_edge;
   logic      row_adv;
   step_dir_e eff_dir;
   step_dir_e col_dir;

   assign load_g  = chip_en && xfer_start;
   assign step_g  = chip_en && rw_step && !xfer_start;
   assign col_dir = load_g ? step_dir_e'(dir_up) : eff_dir;

   serial_addr_seq_mode u_mode (
      .clk        (clk),
      .rst        (rst),
      .chip_i     (chip_en),
      .load_i     (load_g),
      .step_i     (step_g),
      .rw_raw_i   (rw_step),
      .dir_in_i   (dir_up),
      .fast_n_i   (fast_n),
      .col_edge_i (col_edge),
      .eff_dir_o  (eff_dir),
      .dir_o      (dir_now),
      .fast_o     (fast_on),
      .pend_o     (row_pending),
      .row_adv_o  (row_adv),
      .oe_o       (data_oe)
   );

   serial_addr_seq_col #(.COL_W(COL_W)) u_col (
      .clk    (clk),
      .rst    (rst),
      .load_i (load_g),
      .step_i (step_g),
      .dir_i  (col_dir),
      .col_o  (col_addr),
      .edge_o (col_edge)
   );

   serial_addr_seq_row #(.ROW_W(ROW_W)) u_row (
      .clk    (clk),
      .rst    (rst),
      .load_i (load_g),
      .ext_i  (ext_row),
      .adv_i  (row_adv),
      .dir_i  (eff_dir),
      .row_o  (row_addr)
   );
endmodule

// File: rtl/serial_addr_seq_chk.sv
module serial_addr_seq_chk #(
   parameter int ROW_W = 8,
   parameter int COL_W = 10
) (
   input logic             clk,
   input logic             rst,
   input logic             chip_en,
   input logic             xfer_start,
   input logic             rw_step,
   input logic             dir_up,
   input logic             fast_n,
   input logic [ROW_W-1:0] ext_row,
   input logic [ROW_W-1:0] row_addr,
   input logic [COL_W-1:0] col_addr,
   input logic             dir_now,
   input logic             fast_on,
   input logic             row_pending,
   input logic             data_oe
);
   p_load_up_r2: assert property (@(posedge clk) disable iff (rst)
      chip_en && xfer_start && dir_up |=> col_addr == '0 && row_addr == $past(ext_row));

   p_load_down_r3: assert property (@(posedge clk) disable iff (rst)
      chip_en && xfer_start && !dir_up |=> col_addr == {COL_W{1'b1}} && row_addr == $past(ext_row));

   p_up_step_r5: assert property (@(posedge clk) disable iff (rst)
      chip_en && rw_step && !xfer_start && !fast_on && dir_up
      |=> col_addr == COL_W'($past(col_addr) + COL_W'(1)) && dir_now);

   p_fast_gate_r6: assert property (@(posedge clk) disable iff (rst)
      rw_step |=> $stable(fast_on));

   p_fast_row_hold_r7: assert property (@(posedge clk) disable iff (rst)
      chip_en && rw_step && !xfer_start && fast_on |=> $stable(row_addr) && $stable(dir_now));

   p_pend_clear_r8: assert property (@(posedge clk) disable iff (rst)
      chip_en && rw_step && !xfer_start && !fast_on |=> !row_pending);

   p_chip_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !chip_en |=> $stable(row_addr) && $stable(col_addr) && $stable(fast_on) && $stable(row_pending));

   p_oe_off_r9: assert property (@(posedge clk) disable iff (rst)
      !chip_en |=> !data_oe);

   p_load_clears_r11: assert property (@(posedge clk) disable iff (rst)
      chip_en && xfer_start |=> !row_pending && data_oe);
endmodule

bind serial_addr_seq serial_addr_seq_chk #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .chip_en     (chip_en),
   .xfer_start  (xfer_start),
   .rw_step     (rw_step),
   .dir_up      (dir_up),
   .fast_n      (fast_n),
   .ext_row     (ext_row),
   .row_addr    (row_addr),
   .col_addr    (col_addr),
   .dir_now     (dir_now),
   .fast_on     (fast_on),
   .row_pending (row_pending),
   .data_oe     (data_oe)
);

// File: tb/serial_addr_seq_tb.sv
`timescale 1ns/1ps
module serial_addr_seq_tb;
   localparam int ROW_W = 3;
   localparam int COL_W = 4;
   localparam logic [COL_W-1:0] CTOP = {COL_W{1'b1}};

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             chip_en = 1'b0;
   logic             xfer_start = 1'b0;
   logic             rw_step = 1'b0;
   logic             dir_up = 1'b1;
   logic             fast_n = 1'b1;
   logic [ROW_W-1:0] ext_row = '0;
   logic [ROW_W-1:0] row_addr;
   logic [COL_W-1:0] col_addr;
   logic             dir_now, fast_on, row_pending, data_oe;

   always #4 clk = ~clk;

   serial_addr_seq #(.ROW_W(ROW_W), .COL_W(COL_W)) u_dut (
      .clk(clk), .rst(rst), .chip_en(chip_en), .xfer_start(xfer_start),
      .rw_step(rw_step), .dir_up(dir_up), .fast_n(fast_n), .ext_row(ext_row),
      .row_addr(row_addr), .col_addr(col_addr), .dir_now(dir_now),
      .fast_on(fast_on), .row_pending(row_pending), .data_oe(data_oe)
   );

   typedef struct packed {
      logic [ROW_W-1:0] row;
      logic [COL_W-1:0] col;
      logic             dir;
      logic             fast;
      logic             pend;
      logic             oe;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   exp_t  m;
   logic  m_active;
   int    n_chk = 0;
   int    n_bad = 0;
   bit    done = 0;

   // reference model: next state from the requirements
   task automatic model_step(input logic ce, st, rs, du, fn, input logic [ROW_W-1:0] ext);
      logic eff, wrap;
      if (ce) begin
         if (st) begin                                     // R2 R3 R11
            m.row  = ext;
            m.col  = du ? '0 : CTOP;
            m.dir  = du;
            m.pend = 1'b0;
            m_active = 1'b1;
         end else if (rs) begin
            eff  = m.fast ? m.dir : du;                    // R5 R7
            wrap = eff ? (m.col == CTOP) : (m.col == '0);
            m.col = eff ? m.col + 1'b1 : m.col - 1'b1;
            if (m.fast) begin
               if (wrap) m.pend = 1'b1;                    // R7
            end else begin
               if (wrap || m.pend) m.row = eff ? m.row + 1'b1 : m.row - 1'b1; // R4 R8
               m.pend = 1'b0;
            end
            m.dir = eff;
         end
         if (!rs) m.fast = !fn;                            // R6
         m.oe = m_active;                                  // R10
      end else begin
         m.oe = 1'b0;                                      // R9
      end
   endtask

   task automatic drive(input logic ce, st, rs, du, fn, input logic [ROW_W-1:0] ext,
                        input string tag);
      @(negedge clk);
      chip_en = ce; xfer_start = st; rw_step = rs; dir_up = du; fast_n = fn; ext_row = ext;
      @(posedge clk);
      model_step(ce, st, rs, du, fn, ext);
      exp_q.push_back(m);
      tag_q.push_back(tag);
   endtask

   // monitor: compare after each edge, away from it
   initial begin
      forever begin
         @(negedge clk);
         if (exp_q.size() > 0) begin
            exp_t  e;
            exp_t  a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = '{row_addr, col_addr, dir_now, fast_on, row_pending, data_oe};
            n_chk++;
            if (a !== e) begin
               n_bad++;
               $display("FAIL %s: row/col/dir/fast/pend/oe actual %0d/%0d/%0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d/%0d/%0d",
                        t, a.row, a.col, a.dir, a.fast, a.pend, a.oe,
                        e.row, e.col, e.dir, e.fast, e.pend, e.oe);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      m = '{row: '0, col: '0, dir: 1'b1, fast: 1'b0, pend: 1'b0, oe: 1'b0};
      m_active = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_chk++;                                             // R1 reset state
      if ({row_addr, col_addr, dir_now, fast_on, row_pending, data_oe} !== {m.row, m.col, m.dir, m.fast, m.pend, m.oe}) begin
         n_bad++;
         $display("FAIL R1: actual %0d/%0d/%0d/%0d/%0d/%0d expected 0/0/1/0/0/0",
                  row_addr, col_addr, dir_now, fast_on, row_pending, data_oe);
      end
      rst = 1'b0;
      // R2: load going up, then count up to the wrap (R4)
      drive(1, 1, 0, 1, 1, 3'd5, "R2 load up");
      drive(1, 0, 0, 1, 1, 3'd0, "R10 oe held");
      for (int i = 0; i < 16; i++) drive(1, 0, 1, 1, 1, 3'd0, "R4 up wrap");
      // R3: load going down from row 0, wrap under to row 7
      drive(1, 1, 0, 0, 1, 3'd0, "R3 load down");
      for (int i = 0; i < 17; i++) drive(1, 0, 1, 0, 1, 3'd0, "R4 down wrap");
      // R5: direction change takes effect on the same step
      drive(1, 0, 1, 1, 1, 3'd0, "R5 switch up");
      drive(1, 0, 1, 0, 1, 3'd0, "R5 switch down");
      // R6: fast select during a step is ignored, then taken
      drive(1, 0, 1, 1, 0, 3'd0, "R6 gated");
      drive(1, 0, 0, 1, 0, 3'd0, "R6 enter");
      // R7: direction frozen, wrap sets pending with row held
      for (int i = 0; i < 18; i++) drive(1, 0, 1, (i % 2 == 0), 0, 3'd0, "R7 fast run");
      // R8: leave fast mode, next normal step settles the row
      drive(1, 0, 0, 0, 1, 3'd0, "R8 leave");
      drive(1, 0, 1, 0, 1, 3'd0, "R8 deferred step");
      drive(1, 0, 1, 0, 1, 3'd0, "R8 plain step");
      // R9: chip disabled, everything ignored
      drive(0, 1, 0, 1, 0, 3'd6, "R9 start ignored");
      drive(0, 0, 1, 1, 0, 3'd6, "R9 step ignored");
      drive(0, 0, 0, 0, 0, 3'd6, "R9 fast ignored");
      // R11: load and step together, load wins; load clears pending
      drive(1, 1, 1, 1, 1, 3'd2, "R11 start over step");
      drive(1, 0, 0, 1, 0, 3'd0, "R11 fast on");
      for (int i = 0; i < 16; i++) drive(1, 0, 1, 1, 0, 3'd0, "R11 fast wrap");
      drive(1, 1, 0, 0, 0, 3'd4, "R11 load clears pend");
      drive(1, 0, 0, 1, 1, 3'd0, "R10 idle");
      @(negedge clk);
      @(negedge clk);
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule